// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel keeps a low byte and a high byte. A 3-bit mode code picks how the bytes count. The modes are a 13-bit count behind a 5-bit prescaler, a plain 16-bit count, an 8-bit count that reloads from the high byte, and, on channel 0 only, a split arrangement that turns channel 0 into two independent 8-bit timers. A channel advances on clock cycles where its run input and its count-pulse input are both high. Its sticky overflow flag is set on rollover and stays set until a clear pulse removes it.

Software loads either byte of either channel through a single write port. The current count of each channel is always visible on a 16-bit output, with the high byte in the upper half. In split mode, channel 0's high byte borrows channel 1's run input and channel 1's flag. Channel 1 then freezes. Mode codes with no defined function freeze the channel, so the channel never produces undefined behaviour.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset both counts read 0x0000 and both overflow flags read 0.
- R2: A channel in mode 001 or 010 advances by one on each clock where its run and pulse inputs are both 1, and holds otherwise. Raising run does not clear the count.
- R3: Code 000 forms a 13-bit count. Bits 4:0 of the low byte act as a divide-by-32 prescaler, and a carry out of bit 4 increments the high byte. Low byte bits 7:5 always read 0, including after a write.
- R4: Code 001 chains the low byte into the high byte as one 16-bit counter with no prescaler.
- R5: Code 010 counts only the low byte. When the low byte rolls over from 0xFF, it loads the high byte value instead of 0, and the high byte does not change.
- R6: When the active count rolls over to zero, the channel's flag (flag_o bit = channel number) is set. It stays set until flag_clr_i for that channel is 1 for a cycle. A clear arriving in the same cycle as a new rollover leaves the flag set.
- R7: Code 011 on channel 0 splits that channel into two timers. Its low byte counts with run_i[0]/pulse_i[0] and sets flag 0. Its high byte counts every clock while run_i[1] is 1, ignores pulse inputs, and sets flag 1 on rollover. Channel 1 holds its count.
- R8: Codes 100, 101, 110 and 111 freeze the channel's count and never set its flag.
- R9: A write (wr_en_i=1; wr_chan_i selects the channel; wr_hi_i=1 selects the high byte, 0 the low byte) stores wr_data_i. The stored value replaces any increment of that byte in the same cycle. Writes to one channel leave the other channel's count alone.
- R10: Code 011 on channel 1 is treated like a reserved code: channel 1 holds and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode0_i | input | 3 | Mode code of channel 0 |
| mode1_i | input | 3 | Mode code of channel 1 |
| run_i | input | 2 | Run enable per channel |
| pulse_i | input | 2 | Count pulse per channel |
| wr_en_i | input | 1 | Byte write strobe |
| wr_chan_i | input | 1 | Channel written |
| wr_hi_i | input | 1 | 1: high byte, 0: low byte |
| wr_data_i | input | 8 | Write data |
| flag_clr_i | input | 2 | Flag clear per channel |
| cnt0_o | output | 16 | Channel 0 count {high, low} |
| cnt1_o | output | 16 | Channel 1 count {high, low} |
| flag_o | output | 2 | Overflow flag per channel |

## Verification
Counting is exercised with run and pulse each toggled on their own. This separates gating by run from gating by pulse, and shows that restarting keeps the old count. Preloads placed just below rollover in each mode separate the three carry rules: the 5-bit prescaler wrap, the 16-bit chain, and the reload from the high byte. Split mode is driven with pulses removed while run_i[1] stays high, which shows whether the high byte counts clock ticks and whether channel 1 truly freezes. Writes that coincide with increments, and clears that coincide with rollovers, test the precedence rules.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        TM_13    = 3'd0,
        TM_16    = 3'd1,
        TM_RLD   = 3'd2,
        TM_SPLIT = 3'd3,
        TM_HOLD  = 3'd4
    } tmode_e;
endpackage

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec
    import timer_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b0
) (
    input  logic [MODE_W-1:0] code_i,
    output tmode_e            mode_o
);
    tmode_e split_variant;

    generate
        if (SPLIT_OK) begin : g_split
            assign split_variant = TM_SPLIT;
        end else begin : g_nosplit
            assign split_variant = TM_HOLD;
        end
    endgenerate

    always_comb begin
        unique case (code_i)
            3'b000:  mode_o = TM_13;
            3'b001:  mode_o = TM_16;
            3'b010:  mode_o = TM_RLD;
            3'b011:  mode_o = split_variant;
            default: mode_o = TM_HOLD;
        endcase
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import timer_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRE_W    = 5,
    parameter bit SPLIT_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] code_i,
    input  logic              run_i,
    input  logic              pulse_i,
    input  logic              halt_i,
    input  logic              alt_run_i,
    input  logic              ext_set_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              clr_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              flag_o,
    output logic              split_o,
    output logic              alt_ovf_o
);
    localparam logic [BYTE_W-1:0] ONE      = BYTE_W'(1);
    localparam logic [BYTE_W-1:0] PRE_MASK = BYTE_W'((1 << PRE_W) - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              flag;
    } chan_state_t;

    chan_state_t s_d, s_q;
    tmode_e      mode;
    logic        tick;
    logic        set_lo, set_hi;

    tmr_mode_dec #(.SPLIT_OK(SPLIT_OK)) u_dec (
        .code_i (code_i),
        .mode_o (mode)
    );

    assign split_o   = (mode == TM_SPLIT);
    assign alt_ovf_o = (mode == TM_SPLIT) && alt_run_i && (&s_q.hi) && !wr_hi_i;
    assign tick      = run_i && pulse_i && !halt_i && !wr_lo_i;

    always_comb begin
        s_d    = s_q;
        set_lo = 1'b0;
        set_hi = 1'b0;
        unique case (mode)
            TM_13: begin
                if (tick) begin
                    s_d.lo = (s_q.lo + ONE) & PRE_MASK;
                    if (&s_q.lo[PRE_W-1:0]) begin
                        s_d.hi = s_q.hi + ONE;
                        set_hi = &s_q.hi;
                    end
                end else begin
                    s_d.lo = s_q.lo & PRE_MASK;
                end
            end
            TM_16: begin
                if (tick) begin
                    s_d.lo = s_q.lo + ONE;
                    if (&s_q.lo) begin
                        s_d.hi = s_q.hi + ONE;
                        set_hi = &s_q.hi;
                    end
                end
            end
            TM_RLD: begin
                if (tick) begin
                    if (&s_q.lo) begin
                        s_d.lo = s_q.hi;
                        set_lo = 1'b1;
                    end else begin
                        s_d.lo = s_q.lo + ONE;
                    end
                end
            end
            TM_SPLIT: begin
                if (tick) begin
                    s_d.lo = s_q.lo + ONE;
                    set_lo = &s_q.lo;
                end
                if (alt_run_i) begin
                    s_d.hi = s_q.hi + ONE;
                end
            end
            default: ;
        endcase

        if (wr_lo_i) begin
            s_d.lo = (mode == TM_13) ? (wr_data_i & PRE_MASK) : wr_data_i;
        end
        if (wr_hi_i) begin
            s_d.hi = wr_data_i;
            set_hi = 1'b0;
        end
        s_d.flag = (s_q.flag && !clr_i) || set_lo || set_hi || ext_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lo_o   = s_q.lo;
    assign hi_o   = s_q.hi;
    assign flag_o = s_q.flag;

    // R8
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_HOLD && !wr_lo_i && !wr_hi_i) |=> $stable({s_q.lo, s_q.hi}));

    // R3
    pre_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_13) |=> (s_q.lo[BYTE_W-1:PRE_W] == '0));

    // R5
    reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_RLD && !wr_hi_i) |=> $stable(s_q.hi));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !clr_i) |=> s_q.flag);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && (mode == TM_16 || mode == TM_RLD)) |=> $stable(s_q.lo));
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
    import timer_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode0_i,
    input  logic [MODE_W-1:0]   mode1_i,
    input  logic [1:0]          run_i,
    input  logic [1:0]          pulse_i,
    input  logic                wr_en_i,
    input  logic                wr_chan_i,
    input  logic                wr_hi_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic [1:0]          flag_clr_i,
    output logic [2*BYTE_W-1:0] cnt0_o,
    output logic [2*BYTE_W-1:0] cnt1_o,
    output logic [1:0]          flag_o
);
    localparam int N_CH = 2;

    logic [MODE_W-1:0] mode_sel [N_CH];
    logic [BYTE_W-1:0] lo_w     [N_CH];
    logic [BYTE_W-1:0] hi_w     [N_CH];
    logic [N_CH-1:0]   split_w, alt_ovf_w, flag_w;

    assign mode_sel[0] = mode0_i;
    assign mode_sel[1] = mode1_i;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam int OTHER = N_CH - 1 - i;
        logic sel_me;
        assign sel_me = wr_en_i && (wr_chan_i == 1'(i));

        tmr_chan #(
            .BYTE_W   (BYTE_W),
            .PRE_W    (PRE_W),
            .SPLIT_OK (i == 0)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .code_i    (mode_sel[i]),
            .run_i     (run_i[i]),
            .pulse_i   (pulse_i[i]),
            .halt_i    (split_w[OTHER]),
            .alt_run_i (run_i[OTHER]),
            .ext_set_i (alt_ovf_w[OTHER]),
            .wr_lo_i   (sel_me && !wr_hi_i),
            .wr_hi_i   (sel_me && wr_hi_i),
            .wr_data_i (wr_data_i),
            .clr_i     (flag_clr_i[i]),
            .lo_o      (lo_w[i]),
            .hi_o      (hi_w[i]),
            .flag_o    (flag_w[i]),
            .split_o   (split_w[i]),
            .alt_ovf_o (alt_ovf_w[i])
        );
    end

    assign cnt0_o = {hi_w[0], lo_w[0]};
    assign cnt1_o = {hi_w[1], lo_w[1]};
    assign flag_o = flag_w;

    // R7
    split_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0_i == 3'b011 && !(wr_en_i && wr_chan_i)) |=> $stable(cnt1_o));

    // R10
    ch1_split_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1_i == 3'b011 && mode0_i != 3'b011 && !(wr_en_i && wr_chan_i)) |=> $stable(cnt1_o));
endmodule

// File: tb/tb_dual_timer_unit.sv
module tb_dual_timer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode0 = 3'b000, mode1 = 3'b000;
    logic [1:0]  run = 2'b00, pulse = 2'b00, clr = 2'b00;
    logic        wr_en = 1'b0, wr_chan = 1'b0, wr_hi = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] cnt0, cnt1;
    logic [1:0]  flags;

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    dual_timer_unit dut (
        .clk(clk), .rst_n(rst_n), .mode0_i(mode0), .mode1_i(mode1),
        .run_i(run), .pulse_i(pulse), .wr_en_i(wr_en), .wr_chan_i(wr_chan),
        .wr_hi_i(wr_hi), .wr_data_i(wr_data), .flag_clr_i(clr),
        .cnt0_o(cnt0), .cnt1_o(cnt1), .flag_o(flags)
    );

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        run = 2'b00; pulse = 2'b00; clr = 2'b00; wr_en = 1'b0;
    endtask

    task automatic wr(bit ch, bit hi, logic [7:0] d);
        wr_en = 1'b1; wr_chan = ch; wr_hi = hi; wr_data = d;
        cycles(1);
        wr_en = 1'b0;
    endtask

    task automatic clear(logic [1:0] m);
        clr = m;
        cycles(1);
        clr = 2'b00;
    endtask

    task automatic expect_v(string req, int sel, logic [15:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    // monitor: compares queued expectations one time unit after a falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.sel)
                    0:       act = cnt0;
                    1:       act = cnt1;
                    default: act = {14'd0, flags};
                endcase
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_v("R1", 0, 16'h0000); expect_v("R1", 1, 16'h0000); expect_v("R1", 2, 16'h0000);
        cycles(1);

        // R2/R4 basic counting and gating
        mode0 = 3'b001; mode1 = 3'b001;
        run = 2'b01; pulse = 2'b01; cycles(5);
        expect_v("R4 count", 0, 16'h0005);
        pulse = 2'b00; cycles(3);
        expect_v("R2 no pulse", 0, 16'h0005);
        run = 2'b00; pulse = 2'b01; cycles(3);
        expect_v("R2 no run", 0, 16'h0005);
        run = 2'b01; pulse = 2'b00; cycles(1);
        expect_v("R2 run keeps count", 0, 16'h0005);

        // R4/R6 16-bit rollover and sticky flag
        idle(); wr(0, 1, 8'hFF); wr(0, 0, 8'hFF);
        expect_v("R9 write", 0, 16'hFFFF);
        run = 2'b01; pulse = 2'b01; cycles(1);
        expect_v("R4 wrap", 0, 16'h0000); expect_v("R6 set", 2, 16'h0001);
        cycles(2);
        expect_v("R6 sticky", 2, 16'h0001); expect_v("R4", 0, 16'h0002);
        idle(); wr(0, 1, 8'h12); wr(0, 0, 8'hFF);
        run = 2'b01; pulse = 2'b01; cycles(1);
        expect_v("R4 carry", 0, 16'h1300);

        // R6 clear, and clear colliding with rollover
        idle(); clear(2'b01);
        expect_v("R6 clear", 2, 16'h0000);
        wr(0, 1, 8'hFF); wr(0, 0, 8'hFF);
        run = 2'b01; pulse = 2'b01; clr = 2'b01; cycles(1);
        expect_v("R6 clr vs ovf", 2, 16'h0001); expect_v("R6", 0, 16'h0000);
        idle(); clear(2'b01);

        // R3 13-bit prescaled mode
        mode0 = 3'b000;
        wr(0, 1, 8'h00); wr(0, 0, 8'hFF);
        expect_v("R3 masked write", 0, 16'h001F);
        run = 2'b01; pulse = 2'b01; cycles(1);
        expect_v("R3 prescaler carry", 0, 16'h0100);
        cycles(31);
        expect_v("R3 prescaler", 0, 16'h011F);
        cycles(1);
        expect_v("R3 second carry", 0, 16'h0200);
        idle(); wr(0, 1, 8'hFF); wr(0, 0, 8'h1F);
        run = 2'b01; pulse = 2'b01; cycles(1);
        expect_v("R3 wrap", 0, 16'h0000); expect_v("R3 flag", 2, 16'h0001);
        idle(); clear(2'b01);

        // R5 auto-reload
        mode0 = 3'b010;
        wr(0, 1, 8'hF0); wr(0, 0, 8'hFE);
        run = 2'b01; pulse = 2'b01; cycles(1);
        expect_v("R5", 0, 16'hF0FF);
        cycles(1);
        expect_v("R5 reload", 0, 16'hF0F0); expect_v("R5 flag", 2, 16'h0001);
        cycles(3);
        expect_v("R5 after reload", 0, 16'hF0F3);
        idle(); clear(2'b01);

        // R9 write priority and channel isolation
        mode0 = 3'b001;
        wr(0, 1, 8'h00); wr(0, 0, 8'h40);
        run = 2'b01; pulse = 2'b01;
        wr(0, 0, 8'h80);
        expect_v("R9 write wins", 0, 16'h0080);
        wr(1, 0, 8'h33);
        expect_v("R9 other chan", 0, 16'h0081); expect_v("R9 ch1", 1, 16'h0033);

        // R8 reserved codes
        idle(); mode0 = 3'b101;
        wr(0, 1, 8'hFF); wr(0, 0, 8'hFF);
        run = 2'b01; pulse = 2'b01; cycles(4);
        expect_v("R8 101", 0, 16'hFFFF); expect_v("R8 flag", 2, 16'h0000);
        mode0 = 3'b111; cycles(2);
        expect_v("R8 111", 0, 16'hFFFF);
        mode0 = 3'b110; cycles(2);
        expect_v("R8 110", 0, 16'hFFFF); expect_v("R8 flag", 2, 16'h0000);

        // R7 split mode
        idle(); mode0 = 3'b011; mode1 = 3'b001;
        wr(0, 1, 8'hFD); wr(0, 0, 8'hFE); wr(1, 0, 8'h10); wr(1, 1, 8'h00);
        run = 2'b11; pulse = 2'b11; cycles(2);
        expect_v("R7 split", 0, 16'hFF00); expect_v("R7 flag0", 2, 16'h0001);
        expect_v("R7 ch1 halted", 1, 16'h0010);
        pulse = 2'b00; cycles(1);
        expect_v("R7 hi ticks", 0, 16'h0000); expect_v("R7 flag1", 2, 16'h0003);
        run = 2'b00; pulse = 2'b11; cycles(2);
        expect_v("R7 hi stops", 0, 16'h0000); expect_v("R7 ch1", 1, 16'h0010);

        // R10 code 011 on channel 1
        idle(); mode0 = 3'b001; clear(2'b11);
        mode1 = 3'b011; run = 2'b10; pulse = 2'b10; cycles(3);
        expect_v("R10 hold", 1, 16'h0010); expect_v("R10 flag", 2, 16'h0000);
        mode1 = 3'b001; cycles(3);
        expect_v("R2 ch1 count", 1, 16'h0013);

        idle(); cycles(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule